// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

A single counter digit that can be configured by parameter as a decimal digit (0 to 9) or a plain binary nibble (0 to 15). It counts up or down on the rising clock edge when its active-low enable is asserted. It can be cleared at any moment. It can also be loaded at any moment from a parallel data word, without a clock edge.

Each stage compares its current value with the terminal value for the selected direction. When that value is reached while the stage is enabled, it pulls its active-low carry output low. To build a wider synchronous counter, every stage is fed from one shared clock, and each stage's carry output drives the enable of the next more significant stage. A decimal stage that holds an illegal code leaves it on the next enabled clock edge.

Top module: `updown_cnt_stage`

## Requirements
- R1: While `clr` is high the count is 0, immediately and without a clock edge. `clr` overrides `ld`, `cnt_en_n` and the clock.
- R2: While `clr` is low and `ld` is high, `cnt` equals `din` at once, without a clock edge. Rising clock edges change nothing while `ld` stays high, and the loaded value is kept after `ld` falls.
- R3: With `clr` and `ld` low, a rising clock edge advances the count only if `cnt_en_n` is 0. If `cnt_en_n` is 1, the count holds.
- R4: `up` = 1 makes an enabled edge add one. `up` = 0 makes it subtract one.
- R5: The count wraps. Counting up, 9 goes to 0 (decimal) and 15 goes to 0 (binary). Counting down, 0 goes to 9 (decimal) and 0 goes to 15 (binary).
- R6: In decimal form, an illegal value 10 to 15 on `din` is loaded unchanged. On the next enabled edge the count becomes 0 when counting up and 9 when counting down. In binary form the same values count normally.
- R7: `carry_n` is 0 exactly when `cnt_en_n` is 0 and `cnt` holds the terminal value: 9 (decimal) or 15 (binary) when `up` = 1, and 0 when `up` = 0. It follows `cnt_en_n` and `up` combinationally. An illegal decimal value never gives a carry.
- R8: Stages that share one clock, with each `carry_n` wired to the next stage's `cnt_en_n`, form one synchronous multi-digit counter. This holds for both directions, for stalls and for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| clr | input | 1 | Asynchronous clear, active high, highest priority |
| ld | input | 1 | Asynchronous parallel load, active high |
| up | input | 1 | Direction: 1 up, 0 down |
| cnt_en_n | input | 1 | Count enable / carry in, active low |
| din | input | W | Parallel load data |
| cnt | output | W | Current count |
| carry_n | output | 1 | Terminal-count carry out, active low |

## Verification
Load and count can fall on the same clock edge. The bench holds `ld` high across a rising edge while `cnt_en_n` is 0, then checks that the loaded value appears before the edge and is still unchanged after it. Clear and load also collide: during reset, `ld` is held high with data on `din` while the clock keeps running, and every stage must read 0. The loaded value must then appear as soon as `clr` is released.

// File: rtl/updown_pkg.sv
`timescale 1ns/1ps
package updown_pkg;
  // Largest legal count for a stage of the given form.
  function automatic int count_limit(bit decimal, int width);
    return decimal ? 9 : (1 << width) - 1;
  endfunction
endpackage

// File: rtl/ctr_next_logic.sv
`timescale 1ns/1ps
module ctr_next_logic #(
  parameter int W = 4,
  parameter logic [W-1:0] LIM = 9
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = 1;

  always_comb begin
    if (up) begin
      // at or beyond the limit (wrap or illegal) -> 0
      nxt = (cur >= LIM) ? '0 : cur + ONE;
    end else begin
      if (cur == '0 || cur > LIM) nxt = LIM;   // wrap or illegal -> limit
      else                        nxt = cur - ONE;
    end
  end
endmodule

// File: rtl/ctr_carry_gen.sv
`timescale 1ns/1ps
module ctr_carry_gen #(
  parameter int W = 4,
  parameter logic [W-1:0] LIM = 9
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  input  logic         cnt_en_n,
  output logic         carry_n
);
  logic at_end;
  assign at_end  = up ? (cur == LIM) : (cur == '0);
  assign carry_n = ~(~cnt_en_n & at_end);
endmodule

// File: rtl/ctr_state_bit.sv
`timescale 1ns/1ps
module ctr_state_bit (
  input  logic clk,
  input  logic clr,
  input  logic ld,
  input  logic d,
  input  logic nxt,
  output logic q
);
  logic force_lo, force_hi;
  assign force_lo = clr | (ld & ~d);
  assign force_hi = ~clr & ld & d;

  always_ff @(posedge clk, posedge force_lo, posedge force_hi) begin
    if (force_lo)      q <= 1'b0;
    else if (force_hi) q <= 1'b1;
    else               q <= nxt;
  end
endmodule

// File: rtl/updown_cnt_stage.sv
`timescale 1ns/1ps
module updown_cnt_stage #(
  parameter int W       = 4,
  parameter bit DECIMAL = 1'b1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic         up,
  input  logic         cnt_en_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cnt,
  output logic         carry_n
);
  import updown_pkg::*;

  localparam int           MAXV = count_limit(DECIMAL, W);
  localparam logic [W-1:0] LIM  = MAXV[W-1:0];
  localparam logic [W-1:0] ONE  = 1;

  logic [W-1:0] nxt, adv;

  ctr_next_logic #(.W(W), .LIM(LIM)) u_next (
    .cur(cnt), .up(up), .nxt(nxt)
  );

  ctr_carry_gen #(.W(W), .LIM(LIM)) u_carry (
    .cur(cnt), .up(up), .cnt_en_n(cnt_en_n), .carry_n(carry_n)
  );

  assign adv = cnt_en_n ? cnt : nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    ctr_state_bit u_bit (
      .clk(clk), .clr(clr), .ld(ld), .d(din[i]), .nxt(adv[i]), .q(cnt[i])
    );
  end

  // Marks that clear or load acted since the previous clock edge.
  logic async_hit;
  always_ff @(posedge clk, posedge ld, posedge clr) begin
    if (clr || ld) async_hit <= 1'b1;
    else           async_hit <= 1'b0;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) clr |-> cnt == '0); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (clr)
    ld |-> cnt == din); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
    (!ld && cnt_en_n) |=> (async_hit || cnt == $past(cnt))); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (clr)
    (!ld && !cnt_en_n && up && cnt < LIM) |=> (async_hit || cnt == $past(cnt) + ONE)); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (clr)
    (!ld && !cnt_en_n && !up && cnt != '0 && cnt <= LIM) |=> (async_hit || cnt == $past(cnt) - ONE)); // R4
  AST_WRAP_ON_CARRY: assert property (@(posedge clk) disable iff (clr)
    (!ld && !carry_n) |=> (async_hit || cnt == ($past(up) ? '0 : LIM))); // R5
  AST_ILLEGAL_EXIT: assert property (@(posedge clk) disable iff (clr)
    (!ld && !cnt_en_n && cnt > LIM) |=> (async_hit || cnt <= LIM)); // R6
endmodule

// File: tb/updown_cnt_stage_bench.sv
`timescale 1ns/1ps
module updown_cnt_stage_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic clr;
  logic a_ld, a_up, a_cin; logic [3:0] a_din, a_q; logic a_co;
  logic h_ld;              logic [3:0] h_din, h_q; logic h_co;
  logic b_ld, b_up, b_cin; logic [3:0] b_din, b_q; logic b_co;

  int tests = 0, fails = 0;
  bit done = 0;

  updown_cnt_stage #(.W(4), .DECIMAL(1'b1)) u_updown_cnt_stage (
    .clk(clk), .clr(clr), .ld(a_ld), .up(a_up), .cnt_en_n(a_cin),
    .din(a_din), .cnt(a_q), .carry_n(a_co));
  updown_cnt_stage #(.W(4), .DECIMAL(1'b1)) u_updown_cnt_stage_hi (
    .clk(clk), .clr(clr), .ld(h_ld), .up(a_up), .cnt_en_n(a_co),
    .din(h_din), .cnt(h_q), .carry_n(h_co));
  updown_cnt_stage #(.W(4), .DECIMAL(1'b0)) u_updown_cnt_stage_bin (
    .clk(clk), .clr(clr), .ld(b_ld), .up(b_up), .cnt_en_n(b_cin),
    .din(b_din), .cnt(b_q), .carry_n(b_co));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {op(1=load pulse,0=clock), cnt_en_n, up, din[3:0], exp cnt[3:0], exp carry_n}
  localparam logic [11:0] VEC [0:16] = '{
    {1'b1, 1'b1, 1'b1, 4'd7,  4'd7, 1'b1},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd8, 1'b1},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd9, 1'b0},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd0, 1'b1},
    {1'b0, 1'b1, 1'b1, 4'd0,  4'd0, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd9, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd8, 1'b1},
    {1'b1, 1'b0, 1'b0, 4'd3,  4'd3, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd2, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd1, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd0, 1'b0},
    {1'b1, 1'b1, 1'b1, 4'd12, 4'd12, 1'b1},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd0, 1'b1},
    {1'b1, 1'b0, 1'b0, 4'd14, 4'd14, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd9, 1'b1},
    {1'b1, 1'b0, 1'b1, 4'd15, 4'd15, 1'b1},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd0, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R8: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ref_v;
    clr = 1'b1;
    a_ld = 1'b1; a_din = 4'd5; a_up = 1'b1; a_cin = 1'b0;
    h_ld = 1'b1; h_din = 4'd5;
    b_ld = 1'b1; b_din = 4'd5; b_up = 1'b1; b_cin = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 clear beats load+clock (lo)", a_q, 0);
    chk("R1 clear beats load+clock (hi)", h_q, 0);
    chk("R1 clear beats load+clock (bin)", b_q, 0);
    clr = 1'b0; #1;
    chk("R2 load appears on clear release", a_q, 5);
    chk("R2 load appears on clear release (bin)", b_q, 5);
    a_ld = 1'b0; h_ld = 1'b0; b_ld = 1'b0; b_cin = 1'b1;
    @(negedge clk); #1;
    chk("R4 first count after load", a_q, 6);

    // table walk on the decimal low stage
    for (int i = 0; i < 17; i++) begin
      logic [11:0] v;
      v = VEC[i];
      a_cin = v[10]; a_up = v[9];
      if (v[11]) begin
        a_din = v[8:5]; a_ld = 1'b1; #2;
        chk($sformatf("R2 async load row %0d", i), a_q, v[8:5]);
        @(negedge clk); a_ld = 1'b0; #1;
        chk($sformatf("R2 clock ignored during load row %0d", i), a_q, v[4:1]);
      end else begin
        @(negedge clk); #1;
        chk($sformatf("R3/R4/R5/R6 count row %0d", i), a_q, v[4:1]);
      end
      chk($sformatf("R7 carry row %0d", i), a_co, v[0]);
    end

    // R7 carry follows enable and direction without a clock
    a_cin = 1'b1; a_up = 1'b1; a_din = 4'd9; a_ld = 1'b1; #1; a_ld = 1'b0; #1;
    a_cin = 1'b0; #0.5;
    chk("R7 carry low at 9 up", a_co, 0);
    a_up = 1'b0; #0.5;
    chk("R7 carry released when down", a_co, 1);
    a_cin = 1'b1; a_up = 1'b1;
    @(negedge clk); #1;
    chk("R3 held with enable high", a_q, 9);

    // R1 asynchronous clear mid-cycle
    clr = 1'b1; #1;
    chk("R1 async clear without clock", a_q, 0);
    clr = 1'b0;

    // binary form
    @(negedge clk); #1;
    b_din = 4'd14; b_ld = 1'b1; #1; b_ld = 1'b0;
    b_cin = 1'b0; b_up = 1'b1;
    @(negedge clk); #1;
    chk("R4 binary up", b_q, 15);
    chk("R7 binary carry at 15", b_co, 0);
    @(negedge clk); #1;
    chk("R5 binary wrap up", b_q, 0);
    b_up = 1'b0; #0.5;
    chk("R7 binary carry at 0 down", b_co, 0);
    @(negedge clk); #1;
    chk("R5 binary wrap down", b_q, 15);
    b_din = 4'd12; b_ld = 1'b1; #1; b_ld = 1'b0; b_up = 1'b1;
    @(negedge clk); #1;
    chk("R6 binary 12 counts normally", b_q, 13);
    b_cin = 1'b1;

    // R8 chained decimal counter
    @(negedge clk); #1;
    clr = 1'b1; #1; clr = 1'b0;
    ref_v = 0; a_cin = 1'b0; a_up = 1'b1;
    for (int k = 0; k < 130; k++) begin
      @(negedge clk); #1;
      ref_v = (ref_v + 1) % 100;
      chk("R8 chain up", h_q * 10 + a_q, ref_v);
    end
    a_up = 1'b0;
    for (int k = 0; k < 45; k++) begin
      @(negedge clk); #1;
      ref_v = (ref_v + 99) % 100;
      chk("R8 chain down", h_q * 10 + a_q, ref_v);
    end
    a_din = 4'd5; h_din = 4'd7; a_ld = 1'b1; h_ld = 1'b1; #1;
    a_ld = 1'b0; h_ld = 1'b0; ref_v = 75;
    chk("R8 chain load", h_q * 10 + a_q, ref_v);
    a_cin = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #1;
      chk("R8 chain stall", h_q * 10 + a_q, ref_v);
    end
    a_cin = 1'b0; a_up = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1;
      ref_v = (ref_v + 1) % 100;
      chk("R8 chain resume", h_q * 10 + a_q, ref_v);
      chk("R8 top carry", h_co, (ref_v == 99) ? 0 : 1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule